// File: doc/BRIEF.md
# Two-Stage Programmable Interrupt Event Router

This block gathers a wide vector of system event lines and turns them into a small number of level-high host interrupt lines. A rising edge on an event line sets that event's pending bit. The bit then stays set until software clears it. Routing takes two programmable steps. A table assigns each event to one of the channels, and a second table assigns each channel to one of the host outputs. Both steps are many-to-one, so any triple of event, channel and host describes one route.

Each host output is high while at least one pending, enabled event reaches it through the two tables and the global enable is set. For each host, a readable status word gives the event that wins a fixed priority: the lowest channel number first, then the lowest event number inside that channel. Hosts 0 and 1 are meant for local processing cores, and hosts 2 to 9 for outside interrupt controllers. The hardware treats all hosts alike.

Configuration goes through a flat register port with word addressing. Writes take effect on the clock edge. Reads are combinational from the address.

Top module: `evt_router`

## Requirements
- R1: After reset all host outputs are low, every pending bit and enable bit reads 0, the global enable reads 0, and every host status word reads 0.
- R2: An event line that is low in one sampled cycle and high in the next sets its pending bit at that edge. A line that stays high does not set the bit again after a clear.
- R3: Writing a 1 to bit b of the pending word at address 0x08 (events 0 to 31) or 0x09 (events 32 to 63) clears event 32*(addr-0x08)+b. Bits written as 0 are left alone. When a new rising edge and a clear of the same event land on the same edge, the pending bit ends up set.
- R4: Per-event enable words at 0x04 (events 0 to 31) and 0x05 (events 32 to 63) mask an event from every host output and status word. A disabled event is still captured as pending.
- R5: Address 0x40+e, bits [3:0], holds the channel of event e. Address 0x20+c, bits [3:0], holds the host of channel c. A code of 10 or more means unmapped, and then no host sees the event or channel. Both tables read back what was written.
- R6: A host output rises in the cycle after the edge that captures a routed, enabled event. It falls in the cycle after the edge that clears or disables the last such event.
- R7: The status word of host h at address 0x30+h has bit 31 set when at least one enabled pending event routes to h. Bits [5:0] then hold the winner: the lowest channel first, then the lowest event. The word is 0 when no such event exists.
- R8: Bit 0 of address 0x00 is the global enable. While it is 0, every host output is low, but pending capture continues and the status words still report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_in | input | 64 | System event lines, sampled for rising edges |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| host_irq | output | 10 | Level-high host interrupt outputs |

## Verification
The hardest case to reach is a new rising edge on an event in the same cycle that software clears it. The bench first pulses the event so that it is pending. It then drops the line and, at one falling clock edge, raises the line and drives the clear write together. The bench also reaches the priority order inside a host by mapping three events across two channels of one host and clearing them one at a time. A long pseudo-random phase mixes table rewrites, unmapped codes and edges, and a behavioural model in the bench checks every cycle.

// File: rtl/evr_pkg.sv
package evr_pkg;
   // Word addresses of the register windows
   localparam int unsigned CTRL_ADDR  = 'h00;
   localparam int unsigned ENA_BASE   = 'h04;
   localparam int unsigned PND_BASE   = 'h08;
   localparam int unsigned CMAP_BASE  = 'h20;
   localparam int unsigned HSTAT_BASE = 'h30;
   localparam int unsigned EMAP_BASE  = 'h40;
   // Largest number of entries each window can hold
   localparam int unsigned WORD_WIN   = 4;
   localparam int unsigned SMALL_WIN  = 16;
   localparam int unsigned EMAP_WIN   = 64;
endpackage

// File: rtl/evr_capture.sv
module evr_capture #(
   parameter int unsigned NUM_EVT = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EVT-1:0] evt_in,
   input  logic [NUM_EVT-1:0] clr_vec,
   output logic [NUM_EVT-1:0] pend
);
   logic [NUM_EVT-1:0] prev_q;
   logic [NUM_EVT-1:0] pend_q;

   // A new edge is ORed in after the clear mask, so the edge wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         pend_q <= '0;
      end else begin
         prev_q <= evt_in;
         pend_q <= (pend_q & ~clr_vec) | (evt_in & ~prev_q);
      end
   end

   assign pend = pend_q;
endmodule

// File: rtl/evr_chan_sel.sv
module evr_chan_sel #(
   parameter int unsigned NUM_EVT  = 64,
   parameter int unsigned NUM_CHAN = 10,
   parameter int unsigned IDX_W    = 4,
   parameter int unsigned EVT_W    = 6
) (
   input  logic [NUM_EVT-1:0]        active,
   input  logic [NUM_EVT*IDX_W-1:0]  emap_flat,
   output logic [NUM_CHAN-1:0]       hit,
   output logic [NUM_CHAN*EVT_W-1:0] evt_flat
);
   for (genvar c = 0; c < NUM_CHAN; c++) begin : g_ch
      logic             c_hit;
      logic [EVT_W-1:0] c_evt;
      // Scan downward so that the lowest matching event is kept last
      always_comb begin
         c_hit = 1'b0;
         c_evt = '0;
         for (int e = NUM_EVT - 1; e >= 0; e--) begin
            if (active[e] && (emap_flat[e*IDX_W +: IDX_W] == IDX_W'(c))) begin
               c_hit = 1'b1;
               c_evt = EVT_W'(e);
            end
         end
      end
      assign hit[c]                    = c_hit;
      assign evt_flat[c*EVT_W +: EVT_W] = c_evt;
   end
endmodule

// File: rtl/evr_host_pick.sv
module evr_host_pick #(
   parameter int unsigned NUM_CHAN = 10,
   parameter int unsigned IDX_W    = 4,
   parameter int unsigned EVT_W    = 6,
   parameter int unsigned HOST_ID  = 0
) (
   input  logic [NUM_CHAN-1:0]       hit,
   input  logic [NUM_CHAN*EVT_W-1:0] evt_flat,
   input  logic [NUM_CHAN*IDX_W-1:0] cmap_flat,
   output logic                      valid,
   output logic [EVT_W-1:0]          evt
);
   // Lowest channel that reaches this host wins
   always_comb begin
      valid = 1'b0;
      evt   = '0;
      for (int c = NUM_CHAN - 1; c >= 0; c--) begin
         if (hit[c] && (cmap_flat[c*IDX_W +: IDX_W] == IDX_W'(HOST_ID))) begin
            valid = 1'b1;
            evt   = evt_flat[c*EVT_W +: EVT_W];
         end
      end
   end
endmodule

// File: rtl/evt_router.sv
module evt_router
   import evr_pkg::*;
#(
   parameter int unsigned NUM_EVT  = 64,
   parameter int unsigned NUM_CHAN = 10,
   parameter int unsigned NUM_HOST = 10,
   parameter int unsigned IDX_W    = 4,
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EVT-1:0] evt_in,
   input  logic               reg_we,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   output logic [NUM_HOST-1:0] host_irq
);
   localparam int unsigned EVT_W     = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;
   localparam int unsigned NUM_WORDS = (NUM_EVT + DATA_W - 1) / DATA_W;

   // Elaboration-time parameter checks
   if (NUM_CHAN >= (2 ** IDX_W)) begin : g_bad_chan
      $error("evt_router: IDX_W needs a spare code above NUM_CHAN-1");
   end
   if (NUM_HOST >= (2 ** IDX_W)) begin : g_bad_host
      $error("evt_router: IDX_W needs a spare code above NUM_HOST-1");
   end
   if (NUM_CHAN > SMALL_WIN || NUM_HOST > SMALL_WIN) begin : g_bad_win
      $error("evt_router: channel or host count exceeds its address window");
   end
   if (NUM_EVT > EMAP_WIN || NUM_WORDS > WORD_WIN) begin : g_bad_evt
      $error("evt_router: event count exceeds its address windows");
   end
   if (ADDR_W < 7 || DATA_W <= EVT_W || DATA_W < IDX_W) begin : g_bad_bus
      $error("evt_router: register port too narrow");
   end

   logic                      glob_q;
   logic [NUM_EVT-1:0]        en_q;
   logic [NUM_EVT*IDX_W-1:0]  emap_q;
   logic [NUM_CHAN*IDX_W-1:0] cmap_q;
   logic [NUM_EVT-1:0]        clr_vec;
   logic [NUM_EVT-1:0]        pend;
   logic [NUM_CHAN-1:0]       ch_hit;
   logic [NUM_CHAN*EVT_W-1:0] ch_evt;
   logic [NUM_HOST-1:0]       h_valid;
   logic [NUM_HOST*EVT_W-1:0] h_evt;

   // Configuration writes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         glob_q <= 1'b0;
         en_q   <= '0;
         emap_q <= '0;
         cmap_q <= '0;
      end else if (reg_we) begin
         if (reg_addr == ADDR_W'(CTRL_ADDR)) glob_q <= reg_wdata[0];
         for (int e = 0; e < NUM_EVT; e++) begin
            if (reg_addr == ADDR_W'(ENA_BASE + e / DATA_W)) en_q[e] <= reg_wdata[e % DATA_W];
            if (reg_addr == ADDR_W'(EMAP_BASE + e)) emap_q[e*IDX_W +: IDX_W] <= reg_wdata[IDX_W-1:0];
         end
         for (int c = 0; c < NUM_CHAN; c++) begin
            if (reg_addr == ADDR_W'(CMAP_BASE + c)) cmap_q[c*IDX_W +: IDX_W] <= reg_wdata[IDX_W-1:0];
         end
      end
   end

   // Write-one-to-clear strobes for the pending words
   always_comb begin
      for (int e = 0; e < NUM_EVT; e++) begin
         clr_vec[e] = reg_we && (reg_addr == ADDR_W'(PND_BASE + e / DATA_W)) && reg_wdata[e % DATA_W];
      end
   end

   evr_capture #(.NUM_EVT(NUM_EVT)) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt_in  (evt_in),
      .clr_vec (clr_vec),
      .pend    (pend)
   );

   evr_chan_sel #(
      .NUM_EVT (NUM_EVT),
      .NUM_CHAN(NUM_CHAN),
      .IDX_W   (IDX_W),
      .EVT_W   (EVT_W)
   ) u_sel (
      .active   (pend & en_q),
      .emap_flat(emap_q),
      .hit      (ch_hit),
      .evt_flat (ch_evt)
   );

   for (genvar h = 0; h < NUM_HOST; h++) begin : g_host
      evr_host_pick #(
         .NUM_CHAN(NUM_CHAN),
         .IDX_W   (IDX_W),
         .EVT_W   (EVT_W),
         .HOST_ID (h)
      ) u_pick (
         .hit      (ch_hit),
         .evt_flat (ch_evt),
         .cmap_flat(cmap_q),
         .valid    (h_valid[h]),
         .evt      (h_evt[h*EVT_W +: EVT_W])
      );
      assign host_irq[h] = h_valid[h] & glob_q;
   end

   // Combinational read mux
   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(CTRL_ADDR)) reg_rdata[0] = glob_q;
      for (int e = 0; e < NUM_EVT; e++) begin
         if (reg_addr == ADDR_W'(ENA_BASE + e / DATA_W)) reg_rdata[e % DATA_W] = en_q[e];
         if (reg_addr == ADDR_W'(PND_BASE + e / DATA_W)) reg_rdata[e % DATA_W] = pend[e];
         if (reg_addr == ADDR_W'(EMAP_BASE + e)) reg_rdata[IDX_W-1:0] = emap_q[e*IDX_W +: IDX_W];
      end
      for (int c = 0; c < NUM_CHAN; c++) begin
         if (reg_addr == ADDR_W'(CMAP_BASE + c)) reg_rdata[IDX_W-1:0] = cmap_q[c*IDX_W +: IDX_W];
      end
      for (int h = 0; h < NUM_HOST; h++) begin
         if (reg_addr == ADDR_W'(HSTAT_BASE + h)) begin
            reg_rdata[DATA_W-1]  = h_valid[h];
            reg_rdata[EVT_W-1:0] = h_evt[h*EVT_W +: EVT_W];
         end
      end
   end
endmodule

// File: rtl/evr_checker.sv
module evr_checker
   import evr_pkg::*;
#(
   parameter int unsigned NUM_EVT  = 64,
   parameter int unsigned NUM_HOST = 10,
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NUM_EVT-1:0]  evt_in,
   input logic [NUM_EVT-1:0]  pend,
   input logic                glob_en,
   input logic [NUM_HOST-1:0] host_irq,
   input logic                reg_we,
   input logic [ADDR_W-1:0]   reg_addr
);
   localparam int unsigned NUM_WORDS = (NUM_EVT + DATA_W - 1) / DATA_W;

   logic clr_wr;
   assign clr_wr = reg_we && (reg_addr >= ADDR_W'(PND_BASE)) &&
                   (reg_addr < ADDR_W'(PND_BASE + NUM_WORDS));

   // R3: without a clear write, no pending bit drops
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_wr |=> ((pend & $past(pend)) == $past(pend)));

   // R8: global enable low keeps every host output low
   p_off_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !glob_en |-> (host_irq == '0));

   // R4: a host output needs at least one pending event behind it
   p_irq_needs_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (|host_irq) |-> (|pend));

   // R2: a sampled rising edge is pending after the next edge
   for (genvar i = 0; i < NUM_EVT; i++) begin : g_cap
      p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(evt_in[i]) |=> pend[i]);
   end
endmodule

bind evt_router evr_checker #(
   .NUM_EVT (NUM_EVT),
   .NUM_HOST(NUM_HOST),
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .evt_in  (evt_in),
   .pend    (pend),
   .glob_en (glob_q),
   .host_irq(host_irq),
   .reg_we  (reg_we),
   .reg_addr(reg_addr)
);

// File: tb/evt_router_tb.sv
module evt_router_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] evt_in = '0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [9:0]  host_irq;

   int nchk = 0;
   int nerr = 0;
   bit run_cmp = 1'b0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   evt_router u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_in   (evt_in),
      .reg_we   (reg_we),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .host_irq (host_irq)
   );

   // ---------------- behavioural reference model ----------------
   bit [63:0] m_prev, m_pend, m_en, m_rise, m_clr;
   bit        m_glob;
   int        m_emap[64];
   int        m_cmap[10];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_prev = '0; m_pend = '0; m_en = '0; m_glob = 1'b0;
         for (int i = 0; i < 64; i++) m_emap[i] = 0;
         for (int i = 0; i < 10; i++) m_cmap[i] = 0;
      end else begin
         m_rise = evt_in & ~m_prev;
         m_clr  = '0;
         if (reg_we && reg_addr == 8'h08) m_clr[31:0]  = reg_wdata;
         if (reg_we && reg_addr == 8'h09) m_clr[63:32] = reg_wdata;
         m_pend = (m_pend & ~m_clr) | m_rise;
         m_prev = evt_in;
         if (reg_we) begin
            if (reg_addr == 8'h00) m_glob = reg_wdata[0];
            if (reg_addr == 8'h04) m_en[31:0]  = reg_wdata;
            if (reg_addr == 8'h05) m_en[63:32] = reg_wdata;
            if (reg_addr >= 8'h20 && reg_addr <= 8'h29) m_cmap[reg_addr - 8'h20] = int'(reg_wdata[3:0]);
            if (reg_addr >= 8'h40 && reg_addr <= 8'h7f) m_emap[reg_addr - 8'h40] = int'(reg_wdata[3:0]);
         end
      end
   end

   function automatic bit [31:0] exp_stat(int h);
      for (int c = 0; c < 10; c++) begin
         if (m_cmap[c] == h) begin
            for (int e = 0; e < 64; e++) begin
               if (m_pend[e] && m_en[e] && m_emap[e] == c) return 32'h8000_0000 | 32'(e);
            end
         end
      end
      return 32'h0;
   endfunction

   function automatic bit [9:0] exp_irq();
      bit [9:0] r = '0;
      for (int h = 0; h < 10; h++) r[h] = exp_stat(h)[31] & m_glob;
      return r;
   endfunction

   function automatic bit [31:0] exp_rd(bit [7:0] a);
      if (a == 8'h00) return {31'b0, m_glob};
      if (a == 8'h04) return m_en[31:0];
      if (a == 8'h05) return m_en[63:32];
      if (a == 8'h08) return m_pend[31:0];
      if (a == 8'h09) return m_pend[63:32];
      if (a >= 8'h20 && a <= 8'h29) return 32'(m_cmap[a - 8'h20]);
      if (a >= 8'h30 && a <= 8'h39) return exp_stat(a - 8'h30);
      if (a >= 8'h40 && a <= 8'h7f) return 32'(m_emap[a - 8'h40]);
      return 32'h0;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      #2;
      if (rst_n && run_cmp) begin
         chk("R6 host outputs vs model", 32'(host_irq), 32'(exp_irq()));
         chk("R5 readback vs model", reg_rdata, exp_rd(reg_addr));
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic wr(bit [7:0] a, bit [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd_chk(string tag, bit [7:0] a, bit [31:0] exp);
      @(negedge clk);
      reg_addr = a;
      #2;
      chk(tag, reg_rdata, exp);
   endtask

   task automatic irq_chk(string tag, bit [9:0] exp);
      @(negedge clk);
      #2;
      chk(tag, 32'(host_irq), 32'(exp));
   endtask

   task automatic pulse(bit [63:0] m);
      @(negedge clk); evt_in = evt_in | m;
      @(negedge clk); evt_in = evt_in & ~m;
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nchk++; nerr++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end

   // ---------------- directed and random sequence ----------------
   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      run_cmp = 1'b1;

      // R1: reset state
      irq_chk("R1 outputs after reset", 10'h000);
      rd_chk("R1 pending word after reset", 8'h08, 32'h0);
      rd_chk("R1 host status after reset", 8'h32, 32'h0);
      rd_chk("R1 control after reset", 8'h00, 32'h0);

      // Route event 5 -> channel 3 -> host 2
      wr(8'h45, 32'd3);
      wr(8'h23, 32'd2);
      wr(8'h04, 32'h20);
      wr(8'h00, 32'h1);
      rd_chk("R5 event map readback", 8'h45, 32'd3);

      // R6: output rises one cycle after the capturing edge
      @(negedge clk); evt_in[5] = 1'b1;
      #2 chk("R6 not yet high before edge", 32'(host_irq), 32'h0);
      irq_chk("R6 high after capture edge", 10'h004);
      rd_chk("R7 host 2 status", 8'h32, 32'h8000_0005);

      // R2: steady high line does not re-capture after clear
      wr(8'h08, 32'h20);
      #2 chk("R6 low after clear", 32'(host_irq), 32'h0);
      repeat (3) @(negedge clk);
      rd_chk("R2 no recapture while high", 8'h08, 32'h0);
      evt_in[5] = 1'b0;

      // R3: edge wins over simultaneous clear
      pulse(64'h80);
      rd_chk("R2 event 7 captured", 8'h08, 32'h80);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 8'h08; reg_wdata = 32'h80; evt_in[7] = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
      #2 chk("R3 edge wins over clear", reg_rdata, 32'h80);
      wr(8'h08, 32'h80);
      rd_chk("R3 write-one clears", 8'h08, 32'h0);
      evt_in[7] = 1'b0;

      // R4: disabled events are captured but do not interrupt
      wr(8'h04, 32'h0);
      pulse(64'h20);
      rd_chk("R4 disabled event still pending", 8'h08, 32'h20);
      irq_chk("R4 disabled event masked", 10'h000);
      wr(8'h04, 32'h20);
      #2 chk("R4 enable exposes pending", 32'(host_irq), 32'h004);
      wr(8'h04, 32'h0);
      #2 chk("R6 low after disable", 32'(host_irq), 32'h0);
      wr(8'h08, 32'h20);

      // R5: unmapped codes
      wr(8'h46, 32'd10);
      wr(8'h04, 32'h60);
      pulse(64'h40);
      irq_chk("R5 unmapped event code", 10'h000);
      rd_chk("R5 unmapped event has no status", 8'h32, 32'h0);
      wr(8'h46, 32'd4);
      irq_chk("R5 channel 4 defaults to host 0", 10'h001);
      wr(8'h24, 32'd15);
      irq_chk("R5 unmapped channel code", 10'h000);
      wr(8'h24, 32'd9);
      irq_chk("R5 channel 4 to host 9", 10'h200);
      rd_chk("R7 host 9 status", 8'h39, 32'h8000_0006);
      wr(8'h08, 32'h40);

      // R7: priority by channel, then event
      wr(8'h68, 32'd1);
      wr(8'h49, 32'd1);
      wr(8'h21, 32'd2);
      wr(8'h04, 32'h220);
      wr(8'h05, 32'h100);
      @(negedge clk); evt_in = evt_in | 64'h0000_0100_0000_0220;
      @(negedge clk); evt_in = '0;
      rd_chk("R7 lowest event in lowest channel", 8'h32, 32'h8000_0009);
      wr(8'h08, 32'h200);
      rd_chk("R7 next in channel 1", 8'h32, 32'h8000_0028);
      wr(8'h09, 32'h100);
      rd_chk("R7 falls back to channel 3", 8'h32, 32'h8000_0005);
      irq_chk("R7 host 2 still raised", 10'h004);

      // R8: global enable
      wr(8'h00, 32'h0);
      irq_chk("R8 outputs forced low", 10'h000);
      rd_chk("R8 status still reports", 8'h32, 32'h8000_0005);
      pulse(64'h200);
      rd_chk("R8 capture continues", 8'h08, 32'h220);
      wr(8'h00, 32'h1);
      irq_chk("R8 outputs restored", 10'h004);
      rd_chk("R8 status after restore", 8'h32, 32'h8000_0009);
      wr(8'h08, 32'hffff_ffff);
      wr(8'h09, 32'hffff_ffff);

      // Pseudo-random phase checked against the model every cycle
      for (int n = 0; n < 4000; n++) begin
         @(negedge clk);
         evt_in = evt_in ^ ({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
         reg_we = ($urandom % 2) == 0;
         reg_wdata = $urandom;
         case ($urandom % 8)
            0: begin reg_addr = 8'h00; reg_wdata = {31'b0, ($urandom % 4) != 0}; end
            1: reg_addr = 8'h04 + 8'($urandom % 2);
            2: reg_addr = 8'h08 + 8'($urandom % 2);
            3: begin reg_addr = 8'h40 + 8'($urandom % 64); reg_wdata = $urandom % 16; end
            4: begin reg_addr = 8'h20 + 8'($urandom % 16); reg_wdata = $urandom % 16; end
            5: begin reg_addr = 8'h30 + 8'($urandom % 10); reg_we = 1'b0; end
            default: reg_addr = 8'($urandom % 128);
         endcase
      end
      @(negedge clk);
      reg_we = 1'b0;
      repeat (3) @(negedge clk);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule